// File: doc/BRIEF.md
# Two-Level Exception Entry Sequencer

This block is the processor-side control that answers two external interrupt lines: a normal request and a fast request with higher priority. Both lines are active low. It holds a 32-bit status word. The status word carries four condition flags, a disable bit for each request type and a 5-bit mode field.

At each instruction boundary, signalled by a completion strobe, the block looks at the lines. If one is asserted and its disable bit is clear, the block enters the exception. It copies the status word into the saved-status register of the new mode and writes the next-instruction address plus 4 into that mode's link register. It then forces the mode field, sets the disable bits and emits a one-cycle program-counter load with the vector address.

Taking the fast request disables both request types. Taking the normal request disables only itself, so a fast request can still nest inside a normal handler. A return strobe puts the saved status of the current mode back into the status word, which re-enables whatever the entry had masked.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the status word is 0x00000010 (user mode 10000, both disable bits clear, flags zero), `pc_load` is low, and all saved-status and link registers are zero.
- R2: A request is acted on only in a cycle where `insn_done` is high. With `insn_done` low, no entry occurs and `pc_load` stays low in the following cycle.
- R3: A normal entry leaves mode 10010 in bits 4:0 and sets bit 7 (normal disable). It leaves bit 6 (fast disable) unchanged. It pulses `pc_load` for one cycle with target (top of address space − 32) + 0x18, which is 0xFFFFFFF8 for 32-bit addresses.
- R4: A fast entry leaves mode 10001 and sets bits 7 and 6. It pulses `pc_load` with target (top − 32) + 0x1C, which is 0xFFFFFFFC.
- R5: When both lines are asserted and both are unmasked, the fast request is taken.
- R6: The normal request is ignored while bit 7 is set, and the fast request is ignored while bit 6 is set. Inside a normal handler a fast request is still taken.
- R7: On entry the new mode's link register receives `next_pc` + 4. The other mode's link register is not changed.
- R8: On entry the new mode's saved-status register receives the full status word. This includes any flag update made by the instruction completing in that cycle.
- R9: `ret_req` in mode 10010 or 10001 loads the status word from that mode's saved status, and no entry occurs in that cycle. In any other mode the return strobe has no effect.
- R10: A request that is still asserted when its disable bit is cleared by a return is taken at the next instruction boundary.
- R11: `cond_we` together with `insn_done` writes `cond_in` into status bits 31:28 (N, Z, C, V from high to low).
- R12: A line held high is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Normal interrupt request, active low |
| fiq_n | input | 1 | Fast interrupt request, active low |
| insn_done | input | 1 | Current instruction completes this cycle |
| next_pc | input | AW | Address of the next instruction |
| cond_we | input | 1 | Flag update by the completing instruction |
| cond_in | input | 4 | New N, Z, C, V flags |
| ret_req | input | 1 | Exception return strobe |
| status | output | 32 | Current status word |
| pc_load | output | 1 | One-cycle vector load strobe |
| pc_target | output | AW | Vector address to load |
| lr_irq | output | AW | Normal-mode link register |
| lr_fiq | output | AW | Fast-mode link register |
| spsr_irq | output | 32 | Normal-mode saved status |
| spsr_fiq | output | 32 | Fast-mode saved status |

## Verification
The bench uses the default parameters: 32-bit addresses, a 32-byte vector table, and vector offsets 0x18 and 0x1C. With these values both vectors sit in the top word pair of the address space, so the full-width base computation is visible in the checked targets. The bench walks a normal entry, a fast entry nested inside it, returns in both orders, simultaneous requests, and requests held across a return. This covers the asymmetric masking and the case where a return and an entry fall in the same cycle.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam int BIT_I   = 7;
  localparam int BIT_F   = 6;
  localparam int FLAG_LO = 28;
  localparam int ST_W    = 32;

  typedef enum logic [1:0] {TAKE_NONE, TAKE_IRQ, TAKE_FIQ} take_e;
endpackage

// File: rtl/exc_arb.sv
module exc_arb
  import exc_seq_pkg::*;
(
  input  logic  irq_n,
  input  logic  fiq_n,
  input  logic  i_mask,
  input  logic  f_mask,
  input  logic  done,
  input  logic  blocked,
  output take_e take
);
  always_comb begin
    take = TAKE_NONE;
    if (done && !blocked) begin
      if (!fiq_n && !f_mask)      take = TAKE_FIQ;
      else if (!irq_n && !i_mask) take = TAKE_IRQ;
    end
  end
endmodule

// File: rtl/exc_bank.sv
module exc_bank #(
  parameter int AW = 32,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [SW-1:0] st_in,
  input  logic [AW-1:0] lr_in,
  output logic [SW-1:0] st_q,
  output logic [AW-1:0] lr_q
);
  logic [SW-1:0] st_d;
  logic [AW-1:0] lr_d;

  always_comb begin
    st_d = st_q;
    lr_d = lr_q;
    if (cap_en) begin
      st_d = st_in;
      lr_d = lr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      lr_q <= '0;
    end else begin
      st_q <= st_d;
      lr_q <= lr_d;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int AW          = 32,
  parameter int TABLE_BYTES = 32,
  parameter int IRQ_OFS     = 24,
  parameter int FIQ_OFS     = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_n,
  input  logic          fiq_n,
  input  logic          insn_done,
  input  logic [AW-1:0] next_pc,
  input  logic          cond_we,
  input  logic [3:0]    cond_in,
  input  logic          ret_req,
  output logic [31:0]   status,
  output logic          pc_load,
  output logic [AW-1:0] pc_target,
  output logic [AW-1:0] lr_irq,
  output logic [AW-1:0] lr_fiq,
  output logic [31:0]   spsr_irq,
  output logic [31:0]   spsr_fiq
);
  localparam int NBANK = 2;
  localparam logic [AW-1:0] VEC_BASE = ~(AW'(TABLE_BYTES - 1));
  localparam logic [AW-1:0] IRQ_VEC  = VEC_BASE | AW'(IRQ_OFS);
  localparam logic [AW-1:0] FIQ_VEC  = VEC_BASE | AW'(FIQ_OFS);
  localparam logic [AW-1:0] LR_ADJ   = AW'(4);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [ST_W-1:0] st_q, st_d, st_post, ret_src;
  logic            ret_ok;
  take_e           take;
  logic [ST_W-1:0] bank_st [NBANK];
  logic [AW-1:0]   bank_lr [NBANK];
  logic            ld_d;
  logic [AW-1:0]   tgt_d, tgt_q;
  logic            ld_q;

  assign ret_ok  = ret_req && (st_q[4:0] == MODE_IRQ || st_q[4:0] == MODE_FIQ);
  assign ret_src = (st_q[4:0] == MODE_FIQ) ? bank_st[1] : bank_st[0];

  exc_arb u_arb (
    .irq_n   (irq_n),
    .fiq_n   (fiq_n),
    .i_mask  (st_q[BIT_I]),
    .f_mask  (st_q[BIT_F]),
    .done    (insn_done),
    .blocked (ret_ok),
    .take    (take)
  );

  // flags written by the completing instruction come first
  always_comb begin
    st_post = st_q;
    if (insn_done && cond_we) st_post[31:FLAG_LO] = cond_in;
  end

  always_comb begin
    st_d = st_post;
    if (ret_ok) begin
      st_d = ret_src;
    end else begin
      case (take)
        TAKE_IRQ: begin
          st_d[4:0]   = MODE_IRQ;
          st_d[BIT_I] = 1'b1;
        end
        TAKE_FIQ: begin
          st_d[4:0]   = MODE_FIQ;
          st_d[BIT_I] = 1'b1;
          st_d[BIT_F] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
      localparam take_e KIND = (g == 0) ? TAKE_IRQ : TAKE_FIQ;
      exc_bank #(.AW(AW), .SW(ST_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .cap_en (take == KIND),
        .st_in  (st_post),
        .lr_in  (next_pc + LR_ADJ),
        .st_q   (bank_st[g]),
        .lr_q   (bank_lr[g])
      );
    end
  endgenerate

  always_comb begin
    ld_d  = (take != TAKE_NONE);
    tgt_d = (take == TAKE_FIQ) ? FIQ_VEC : IRQ_VEC;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q  <= {{(ST_W-5){1'b0}}, MODE_USR};
      ld_q  <= 1'b0;
      tgt_q <= '0;
    end else begin
      st_q <= st_d;
      ld_q <= ld_d;
      if (ld_d) tgt_q <= tgt_d;
    end
  end

  assign status    = st_q;
  assign pc_load   = ld_q;
  assign pc_target = tgt_q;
  assign spsr_irq  = bank_st[0];
  assign spsr_fiq  = bank_st[1];
  assign lr_irq    = bank_lr[0];
  assign lr_fiq    = bank_lr[1];
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int AW          = 32,
  parameter int TABLE_BYTES = 32,
  parameter int IRQ_OFS     = 24,
  parameter int FIQ_OFS     = 28
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_n,
  input logic          fiq_n,
  input logic          insn_done,
  input logic [AW-1:0] next_pc,
  input logic          ret_req,
  input logic [31:0]   status,
  input logic          pc_load,
  input logic [AW-1:0] pc_target,
  input logic [AW-1:0] lr_irq,
  input logic [AW-1:0] lr_fiq
);
  localparam logic [AW-1:0] BASE  = ~(AW'(TABLE_BYTES - 1));
  localparam logic [AW-1:0] V_IRQ = BASE | AW'(IRQ_OFS);
  localparam logic [AW-1:0] V_FIQ = BASE | AW'(FIQ_OFS);

  p_no_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_done |=> !pc_load);

  p_irq_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && pc_target == V_IRQ) |-> (status[4:0] == 5'b10010 && status[7]));

  p_fiq_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && pc_target == V_FIQ) |-> (status[4:0] == 5'b10001 && status[7] && status[6]));

  p_fiq_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && !fiq_n && !status[6] && !ret_req) |=> (pc_load && pc_target == V_FIQ));

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && fiq_n && status[7]) |=> !pc_load);

  p_lr_fiq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && pc_target == V_FIQ) |-> (lr_fiq == $past(next_pc) + AW'(4)));

  p_lr_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && pc_target == V_IRQ) |-> (lr_irq == $past(next_pc) + AW'(4)));

  p_idle_lines_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && fiq_n) |=> !pc_load);
endmodule

bind exc_entry_seq exc_entry_chk #(
  .AW(AW), .TABLE_BYTES(TABLE_BYTES), .IRQ_OFS(IRQ_OFS), .FIQ_OFS(FIQ_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .irq_n     (irq_n),
  .fiq_n     (fiq_n),
  .insn_done (insn_done),
  .next_pc   (next_pc),
  .ret_req   (ret_req),
  .status    (status),
  .pc_load   (pc_load),
  .pc_target (pc_target),
  .lr_irq    (lr_irq),
  .lr_fiq    (lr_fiq)
);

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_n = 1'b1, fiq_n = 1'b1, insn_done = 1'b0;
  logic [31:0] next_pc = '0;
  logic        cond_we = 1'b0;
  logic [3:0]  cond_in = '0;
  logic        ret_req = 1'b0;
  logic [31:0] status, pc_target, lr_irq, lr_fiq, spsr_irq, spsr_fiq;
  logic        pc_load;
  int total = 0, bad = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  exc_entry_seq u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock, then settle away from the edge
  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(logic d, logic i, logic f, logic r, logic [31:0] pc);
    insn_done = d; irq_n = i; fiq_n = f; ret_req = r; next_pc = pc;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    chk("R1 status", status, 32'h0000_0010);
    chk("R1 pc_load", {31'b0, pc_load}, 0);
    chk("R1 lr_irq", lr_irq, 0);
    chk("R1 spsr_fiq", spsr_fiq, 0);
  endtask

  task automatic t_idle();
    drive(1, 1, 1, 0, 32'h100);
    cyc();
    chk("R12 idle lines no entry", {31'b0, pc_load}, 0);
    chk("R12 status", status, 32'h0000_0010);
    drive(0, 0, 0, 0, 32'h100);
    cyc(); cyc();
    chk("R2 no boundary no entry", {31'b0, pc_load}, 0);
    chk("R2 status", status, 32'h0000_0010);
  endtask

  task automatic t_flags();
    drive(1, 1, 1, 0, 0);
    cond_we = 1; cond_in = 4'hA;
    cyc();
    cond_we = 0;
    chk("R11 flags", status, 32'hA000_0010);
  endtask

  task automatic t_irq();
    drive(1, 0, 1, 0, 32'h1000);
    cyc();
    chk("R3 pc_load", {31'b0, pc_load}, 1);
    chk("R3 target", pc_target, 32'hFFFF_FFF8);
    chk("R3 status", status, 32'hA000_0092);
    chk("R7 lr_irq", lr_irq, 32'h1004);
    chk("R7 lr_fiq untouched", lr_fiq, 0);
    chk("R8 spsr_irq", spsr_irq, 32'hA000_0010);
    drive(0, 0, 1, 0, 0);
    cyc();
    chk("R3 single pulse", {31'b0, pc_load}, 0);
    drive(1, 0, 1, 0, 32'h1100);
    cyc();
    chk("R6 irq masked", {31'b0, pc_load}, 0);
    chk("R6 status kept", status, 32'hA000_0092);
  endtask

  task automatic t_nest_fiq();
    drive(1, 0, 0, 0, 32'h2000);
    cyc();
    chk("R6 fiq nests in irq", {31'b0, pc_load}, 1);
    chk("R4 target", pc_target, 32'hFFFF_FFFC);
    chk("R4 status", status, 32'hA000_00D1);
    chk("R8 spsr_fiq", spsr_fiq, 32'hA000_0092);
    chk("R7 lr_fiq", lr_fiq, 32'h2004);
    chk("R7 lr_irq kept", lr_irq, 32'h1004);
    drive(1, 0, 0, 0, 32'h2100);
    cyc();
    chk("R6 fiq masked", {31'b0, pc_load}, 0);
  endtask

  task automatic t_returns();
    drive(0, 1, 1, 1, 0);
    cyc();
    chk("R9 return from fast", status, 32'hA000_0092);
    drive(1, 0, 0, 1, 32'h2200);
    cyc();
    chk("R9 return wins over entry", {31'b0, pc_load}, 0);
    chk("R9 return from normal", status, 32'hA000_0010);
    drive(0, 0, 0, 0, 0);
    cyc();
    chk("R2 held lines wait", {31'b0, pc_load}, 0);
    drive(1, 0, 0, 0, 32'h3000);
    cond_we = 1; cond_in = 4'h5;
    cyc();
    cond_we = 0;
    chk("R5 fast first", pc_target, 32'hFFFF_FFFC);
    chk("R10 held fast taken", {31'b0, pc_load}, 1);
    chk("R5 status", status, 32'h5000_00D1);
    chk("R8 saved with new flags", spsr_fiq, 32'h5000_0010);
    chk("R7 lr_fiq", lr_fiq, 32'h3004);
    drive(0, 0, 1, 1, 0);
    cyc();
    chk("R9 back to user", status, 32'h5000_0010);
    drive(1, 0, 1, 0, 32'h4000);
    cyc();
    chk("R10 held normal taken", pc_target, 32'hFFFF_FFF8);
    chk("R10 status", status, 32'h5000_0092);
    chk("R7 lr_irq", lr_irq, 32'h4004);
    chk("R8 spsr_irq", spsr_irq, 32'h5000_0010);
    drive(0, 1, 1, 1, 0);
    cyc();
    chk("R9 restore", status, 32'h5000_0010);
  endtask

  task automatic t_user_ret();
    drive(1, 1, 1, 1, 0);
    cond_we = 1; cond_in = 4'hF;
    cyc();
    cond_we = 0;
    drive(0, 1, 1, 0, 0);
    chk("R9 user return ignored", status, 32'hF000_0010);
    chk("R9 spsr_irq kept", spsr_irq, 32'h5000_0010);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_flags();
    t_irq();
    t_nest_fiq();
    t_returns();
    t_user_ret();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule